// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block sits after a clock divider and controls one group of derived clock outputs. All outputs of the group are copies of one source clock. An asynchronous, active-low stop request parks every stoppable output of the group in the low state. When the request is withdrawn, those outputs resume. A per-output enable vector can also hold any single output low. The block is built so that no output ever shows a shortened high phase.

The stop request passes through a chain of flip-flops clocked by the source clock. The synchronized request drives a small run/stop state machine. That machine contains a saturating counter, which makes sure the group runs for a minimum number of cycles before it can be stopped again. A stop request that arrives inside that window stays pending and takes effect once the window closes. The per-output gate enables are captured on the falling edge of the source clock, so they only change during the low phase. One output, chosen by a parameter, is free-running: it ignores the stop request but still obeys its enable bit. Other groups of clocks are not affected, because each group has its own instance.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every `clk_out` bit is held low. After release, each output with its `out_en` bit at 1 toggles from the first rising source edge that follows the next falling edge.
- R2: Each gated output starts and stops only during the low phase of `clk_src`. Every high pulse it emits lasts a full high phase of `clk_src`.
- R3: `stop_req_n` is treated as asynchronous and passes through `SYNC_STAGES` flip-flops. Suppose it falls between two rising edges while the minimum run interval has elapsed. Then the stoppable outputs give exactly `SYNC_STAGES`+1 more full high pulses (3 by default) and are then held low.
- R4: Suppose `stop_req_n` rises between two rising edges while the group is stopped. Then the stoppable outputs stay low for the next `SYNC_STAGES`+1 rising edges and pulse again from the edge after that.
- R5: After a restart, the stoppable outputs emit at least `MIN_RUN` high pulses (100 by default) before they can stop again. If the request is already asserted during that interval, it is held pending and applied as soon as the interval ends. In that case the outputs emit exactly `MIN_RUN` pulses.
- R6: Output bit `FREE_IDX` (bit 0 by default) ignores `stop_req_n` completely and keeps toggling while the rest of the group is stopped.
- R7: `out_en` bit i at 0 holds `clk_out` bit i low with no switching, starting from the next high phase. At 1 it lets the output run. This applies to the free-running bit as well.
- R8: Changing one output's enable bit leaves the other outputs of the group switching unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock of the group; all gated outputs derive from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request for the stoppable outputs |
| out_en | input | N_OUT | Per-output enable, 1 = run, 0 = hold low |
| clk_out | output | N_OUT | Gated clock outputs; bit FREE_IDX is exempt from stopping |

## Verification
Four things are checked by assertions on every cycle:
- The gate enables move only while the source clock is low.
- The run state changes only in the direction the synchronized request asks for.
- A stop never lands before `MIN_RUN` cycles of running.
- The free-running enable always tracks its enable bit, whatever the stop state.

The bench scenarios cover the behaviours that need exact timing: the number of pulses before and after a stop or restart, the exact count when a pending request is released by the minimum-run counter, and the pulse widths seen on the output pins.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);

    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    always_comb begin
        stage_d[0] = async_n;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // Reset value 1 means no stop is requested.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/run_ctrl.sv
`timescale 1ns/1ps
module run_ctrl
    import clk_stop_pkg::*;
#(
    parameter int MIN_RUN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_run,
    output logic run
);

    localparam int CW = (MIN_RUN > 1) ? $clog2(MIN_RUN) : 1;
    localparam logic [CW-1:0] DONE = CW'(MIN_RUN - 1);

    typedef struct packed {
        run_state_e     st;
        logic [CW-1:0]  cnt;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_RUN: begin
                if (ctl_q.cnt != DONE) begin
                    ctl_d.cnt = ctl_q.cnt + CW'(1);
                end
                // A request that is still asserted waits here until the window closes.
                if (!req_run && (ctl_q.cnt == DONE)) begin
                    ctl_d.st = ST_STOP;
                end
            end
            default: begin
                if (req_run) begin
                    ctl_d.st  = ST_RUN;
                    ctl_d.cnt = '0;
                end
            end
        endcase
    end

    // Out of reset, the minimum interval counts as already served.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_RUN, cnt: DONE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run = (ctl_q.st == ST_RUN);

    // Independent run-length tally, used only by the assertion below.
    localparam logic [CW:0] RL_MAX = (CW+1)'(MIN_RUN);
    logic [CW:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= RL_MAX;
        end else if (!run) begin
            run_len_q <= '0;
        end else if (run_len_q != RL_MAX) begin
            run_len_q <= run_len_q + (CW+1)'(1);
        end
    end

    assert_min_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> (run_len_q >= RL_MAX));

endmodule

// File: rtl/gate_bank.sv
`timescale 1ns/1ps
module gate_bank #(
    parameter int N_OUT    = 4,
    parameter int FREE_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [N_OUT-1:0] en,
    output logic [N_OUT-1:0] clk_out
);

    localparam logic [N_OUT-1:0] FREE_MASK = N_OUT'(1) << FREE_IDX;

    logic [N_OUT-1:0] gate_d;
    logic [N_OUT-1:0] gate_q;

    always_comb begin
        gate_d = en & (FREE_MASK | {N_OUT{run}});
    end

    // Falling-edge capture: the enables settle during the low phase.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        assign clk_out[g] = clk & gate_q[g];
    end

    always @(gate_q) begin
        if (rst_n) begin
            assert_gate_low_phase_R2: assert (clk == 1'b0);
        end
    end

    assert_free_exempt_R6: assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (gate_q[FREE_IDX] == $past(en[FREE_IDX])));

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
    parameter int N_OUT       = 4,
    parameter int FREE_IDX    = 0,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RUN     = 100
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             stop_req_n,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] clk_out
);

    logic req_run;
    logic run_q;

    stop_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .async_n (stop_req_n),
        .sync_n  (req_run)
    );

    run_ctrl #(
        .MIN_RUN (MIN_RUN)
    ) u_ctrl (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .req_run (req_run),
        .run     (run_q)
    );

    gate_bank #(
        .N_OUT    (N_OUT),
        .FREE_IDX (FREE_IDX)
    ) u_gate (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .run     (run_q),
        .en      (out_en),
        .clk_out (clk_out)
    );

    assert_fall_needs_req_R3: assert property (@(posedge clk_src) disable iff (!rst_n)
        $fell(run_q) |-> !$past(req_run));

    assert_rise_needs_req_R4: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(run_q) |-> $past(req_run));

endmodule

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/1ps
module tb_clk_stop_gate;

    localparam int N    = 4;
    localparam int SYNC = 2;
    localparam int MINR = 100;
    localparam logic [N-1:0] ALL  = '1;
    localparam logic [N-1:0] FREE = 4'b0001;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_req_n = 1'b1;
    logic [N-1:0] out_en = '1;
    logic [N-1:0] clk_out;

    int total = 0;
    int bad = 0;
    int short_cnt [N];

    always #2.5 clk = ~clk;

    clk_stop_gate #(
        .N_OUT (N), .FREE_IDX (0), .SYNC_STAGES (SYNC), .MIN_RUN (MINR)
    ) dut (
        .clk_src (clk), .rst_n (rst_n), .stop_req_n (stop_req_n),
        .out_en (out_en), .clk_out (clk_out)
    );

    // Pulse-width monitor for R2: each high pulse must last a full 2.5 ns half period.
    for (genvar g = 0; g < N; g++) begin : g_mon
        realtime rise_t = 0.0;
        initial short_cnt[g] = 0;
        always @(posedge clk_out[g]) rise_t = $realtime;
        always @(negedge clk_out[g]) begin
            if (($realtime - rise_t) < 2.4) short_cnt[g] = short_cnt[g] + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            step();
            check(clk_out == '0, "R1 outputs low in reset", clk_out, 0);
        end
        rst_n = 1'b1;
        step();
        check(clk_out == ALL, "R1 outputs run after reset", clk_out, ALL);
    endtask

    task automatic t_stop_latency();
        stop_req_n = 1'b0;
        for (int i = 0; i < SYNC + 1; i++) begin
            step();
            check(clk_out == ALL, "R3 pulses before stop", clk_out, ALL);
        end
        step();
        check(clk_out == FREE, "R3 stopped after latency", clk_out, FREE);
        for (int i = 0; i < 5; i++) begin
            step();
            check(clk_out == FREE, "R6 free output runs while stopped", clk_out, FREE);
        end
    endtask

    task automatic t_restart_minrun();
        int pulses;
        stop_req_n = 1'b1;
        for (int i = 0; i < SYNC + 1; i++) begin
            step();
            check(clk_out == FREE, "R4 still low during on latency", clk_out, FREE);
        end
        step();
        check(clk_out == ALL, "R4 resumed", clk_out, ALL);
        pulses = 1;
        stop_req_n = 1'b0;  // early request, must wait for the minimum interval
        for (int i = 0; i < MINR + 20; i++) begin
            step();
            if (clk_out == ALL) pulses++;
            else if (clk_out != FREE) check(1'b0, "R5 unexpected pattern", clk_out, FREE);
        end
        check(pulses == MINR, "R5 pulses before pending stop", pulses, MINR);
        check(clk_out == FREE, "R5 stopped after interval", clk_out, FREE);
    endtask

    task automatic t_enables();
        stop_req_n = 1'b1;
        for (int i = 0; i < SYNC + 2; i++) step();
        check(clk_out == ALL, "R4 running again", clk_out, ALL);
        out_en = 4'b1011;
        for (int i = 0; i < 3; i++) begin
            step();
            check(clk_out == 4'b1011, "R7 R8 bit2 held low, others run", clk_out, 4'b1011);
        end
        out_en = 4'b1010;
        step();
        check(clk_out == 4'b1010, "R7 free output disabled by enable", clk_out, 4'b1010);
        out_en = ALL;
        step();
        check(clk_out == ALL, "R7 enables restored", clk_out, ALL);
    endtask

    task automatic t_widths();
        for (int i = 0; i < N; i++) begin
            check(short_cnt[i] == 0, "R2 no short high pulse", short_cnt[i], 0);
        end
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_stop_latency();
        t_restart_minrun();
        t_enables();
        t_widths();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule